// File: doc/BRIEF.md
# Cascaded Second-Level Interrupt Aggregator

This block sits between up to 32 level-sensitive interrupt sources and a parent interrupt controller. Software reaches it through a small word-addressed register bus that holds one enable word and one status word. Each enabled, pending source is combined into one or more grouped parent lines. A fixed per-group bit mask picks which source bits feed each line.

A forward mask, fixed when the design is elaborated, marks sources that have a bypass gate. Each forwarded source drives its own dedicated parent line straight from its raw level. It is not registered, and it does not depend on the enable word. Forwarded sources never appear in the status word and never reach a grouped line. Bit positions that no source is wired to never raise anything, whatever the enable word holds.

There are no set or clear registers. Software changes enables only by rewriting the whole enable word. The status word is read-only and is not latched: it mirrors the current source levels.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset the enable word reads 0 and every grouped output is low.
- R2: A write with word address 0 (byte offset 0) stores the full 32-bit enable word in the clock edge of the write. Reads at word address 0 return all 32 bits as written, including bits of forwarded or unconnected positions.
- R3: A read at word address 1 (byte offset 4) returns the status word. Bit i equals the present level of srcIrq[i] when position i is connected and not forwarded, and reads 0 otherwise.
- R4: A write at word address 1 has no effect: the enable word keeps its value.
- R5: Grouped output g is registered. In the cycle after a clock edge it is high exactly when, at that edge, some bit set in all three of status, enable and group mask g was high. It drops one cycle after the contributing sources fall or are disabled.
- R6: The default group masks are 0xEB8 for output 0 (sources 3, 4, 5, 7, 9, 10, 11) and 0x140 for output 1 (sources 6, 8).
- R7: With the default forward mask 0x7, fwdIrq[i] for i in 0..2 follows srcIrq[i] combinationally, regardless of the enable word. These sources never affect a grouped output.
- R8: fwdIrq[i] is held at 0 for every position whose forward bit is clear.
- R9: Unconnected positions (default connect mask 0xFFF, so bits 12..31) never raise a grouped output or a status bit, even when they are enabled and their source is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 1 | Word address: 0 selects the enable word, 1 selects the status word |
| busWr | input | 1 | Write strobe for the addressed word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Combinational read data of the addressed word |
| srcIrq | input | 32 | Level-sensitive interrupt sources |
| grpIrq | output | 2 | Registered grouped parent lines |
| fwdIrq | output | 32 | Dedicated bypass parent lines, one per source position |

## Verification
The bench drives all 32 sources high while every enable bit is set. This checks that forwarded and unconnected positions stay out of both the status word and the grouped lines. A design that leaked them would read back 0xFFF or more instead of 0xFF8, or would raise a line for the wrong group.

A write to the status offset is followed by a read of the enable word. A design that decoded the write wrongly would come back cleared. Enable changes are timed against the registered outputs: the edge that stores a new enable word still uses the old one. An off-by-one in that timing, or a missing register, moves the grouped lines a cycle early or late.

Forwarded lines are checked with their enables cleared. A gate that depended on the enable word would then drop them.

// File: rtl/cascade_irq_pkg.sv
package cascade_irq_pkg;

  // Strobes from the bus decoder to the datapath.
  typedef struct packed {
    logic enableWr;   // store write data into the enable word
    logic statusSel;  // read mux picks the status word
  } ctrlStrobe_t;

endpackage

// File: rtl/cascade_irq_decode.sv
module cascade_irq_decode
  import cascade_irq_pkg::*;
(
  input  logic        busAddr,
  input  logic        busWr,
  output ctrlStrobe_t strobe
);

  // Word 0 is the enable word. Word 1 is the read-only status word.
  always_comb begin
    strobe.statusSel = busAddr;
    strobe.enableWr  = busWr && !busAddr;
  end

endmodule

// File: rtl/cascade_irq_datapath.sv
module cascade_irq_datapath
  import cascade_irq_pkg::*;
#(
  parameter int SRC_W   = 32,
  parameter int NUM_GRP = 2,
  parameter logic [SRC_W-1:0] CONN_MASK = 32'h0000_0FFF,
  parameter logic [SRC_W-1:0] FWD_MASK  = 32'h0000_0007,
  parameter logic [NUM_GRP-1:0][SRC_W-1:0] GRP_MASK = {32'h0000_0140, 32'h0000_0EB8}
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [SRC_W-1:0]   wrData,
  input  logic [SRC_W-1:0]   srcIrq,
  output logic [SRC_W-1:0]   rdData,
  output logic [SRC_W-1:0]   enableWord,
  output logic [NUM_GRP-1:0] grpIrq,
  output logic [SRC_W-1:0]   fwdIrq
);

  // Positions that are wired and take the aggregated path.
  localparam logic [SRC_W-1:0] LIVE_MASK = CONN_MASK & ~FWD_MASK;

  logic [SRC_W-1:0] statusWord;
  logic [SRC_W-1:0] activeBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enableWord <= '0;
    else if (strobe.enableWr) enableWord <= wrData;
  end

  assign statusWord = srcIrq & LIVE_MASK;
  assign activeBits = statusWord & enableWord;
  assign rdData     = strobe.statusSel ? statusWord : enableWord;

  // One registered OR-reduction per parent group.
  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) grpIrq[g] <= 1'b0;
      else       grpIrq[g] <= |(activeBits & GRP_MASK[g]);
    end
  end

  // A bypass gate per position. The gate is present only where the forward bit is set.
  for (genvar i = 0; i < SRC_W; i++) begin : gen_fwd
    if (FWD_MASK[i]) begin : gen_pass
      assign fwdIrq[i] = srcIrq[i];
    end else begin : gen_tie
      assign fwdIrq[i] = 1'b0;
    end
  end

endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
  import cascade_irq_pkg::*;
#(
  parameter int SRC_W   = 32,
  parameter int NUM_GRP = 2,
  parameter logic [SRC_W-1:0] CONN_MASK = 32'h0000_0FFF,
  parameter logic [SRC_W-1:0] FWD_MASK  = 32'h0000_0007,
  parameter logic [NUM_GRP-1:0][SRC_W-1:0] GRP_MASK = {32'h0000_0140, 32'h0000_0EB8}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busAddr,
  input  logic               busWr,
  input  logic [SRC_W-1:0]   busWrData,
  output logic [SRC_W-1:0]   busRdData,
  input  logic [SRC_W-1:0]   srcIrq,
  output logic [NUM_GRP-1:0] grpIrq,
  output logic [SRC_W-1:0]   fwdIrq
);

  ctrlStrobe_t      strobe;
  logic [SRC_W-1:0] enableWord;

  cascade_irq_decode u_decode (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobe  (strobe)
  );

  cascade_irq_datapath #(
    .SRC_W     (SRC_W),
    .NUM_GRP   (NUM_GRP),
    .CONN_MASK (CONN_MASK),
    .FWD_MASK  (FWD_MASK),
    .GRP_MASK  (GRP_MASK)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (busWrData),
    .srcIrq     (srcIrq),
    .rdData     (busRdData),
    .enableWord (enableWord),
    .grpIrq     (grpIrq),
    .fwdIrq     (fwdIrq)
  );

endmodule

// File: rtl/cascade_irq_chk.sv
module cascade_irq_chk #(
  parameter int SRC_W   = 32,
  parameter int NUM_GRP = 2,
  parameter logic [SRC_W-1:0] CONN_MASK = 32'h0000_0FFF,
  parameter logic [SRC_W-1:0] FWD_MASK  = 32'h0000_0007,
  parameter logic [NUM_GRP-1:0][SRC_W-1:0] GRP_MASK = {32'h0000_0140, 32'h0000_0EB8}
) (
  input logic               clk,
  input logic               rstN,
  input logic               busAddr,
  input logic               busWr,
  input logic [SRC_W-1:0]   busRdData,
  input logic [SRC_W-1:0]   srcIrq,
  input logic [SRC_W-1:0]   enableWord,
  input logic [NUM_GRP-1:0] grpIrq,
  input logic [SRC_W-1:0]   fwdIrq
);

  localparam logic [SRC_W-1:0] LIVE_MASK = CONN_MASK & ~FWD_MASK;

  assert_status_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    busAddr |-> ((busRdData & ~LIVE_MASK) == '0));

  assert_status_wr_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr) |=> $stable(enableWord));

  assert_fwd_pass_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((fwdIrq & FWD_MASK) == (srcIrq & FWD_MASK)));

  assert_fwd_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((fwdIrq & ~FWD_MASK) == '0));

  for (genvar g = 0; g < NUM_GRP; g++) begin : gen_grp_chk
    assert_grp_follow_R5: assert property (@(posedge clk) disable iff (!rstN)
      1'b1 |=> (grpIrq[g] == |($past(srcIrq) & $past(enableWord) & LIVE_MASK & GRP_MASK[g])));
  end

endmodule

bind cascade_irq_ctrl cascade_irq_chk #(
  .SRC_W     (SRC_W),
  .NUM_GRP   (NUM_GRP),
  .CONN_MASK (CONN_MASK),
  .FWD_MASK  (FWD_MASK),
  .GRP_MASK  (GRP_MASK)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWr      (busWr),
  .busRdData  (busRdData),
  .srcIrq     (srcIrq),
  .enableWord (enableWord),
  .grpIrq     (grpIrq),
  .fwdIrq     (fwdIrq)
);

// File: tb/test_cascade_irq_ctrl.sv
`timescale 1ns/1ps
module test_cascade_irq_ctrl;

  localparam logic [31:0] CONN = 32'h0000_0FFF;
  localparam logic [31:0] FWD  = 32'h0000_0007;
  localparam logic [31:0] GRP0 = 32'h0000_0EB8;
  localparam logic [31:0] GRP1 = 32'h0000_0140;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busAddr = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [31:0] srcIrq = '0;
  logic [1:0]  grpIrq;
  logic [31:0] fwdIrq;

  cascade_irq_ctrl i_cascade_irq_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .srcIrq    (srcIrq),
    .grpIrq    (grpIrq),
    .fwdIrq    (fwdIrq)
  );

  always #5 clk = ~clk;

  int cycleCnt = 0;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  // Scoreboard item: sel 0 = read data, 1 = grouped lines, 2 = bypass lines.
  typedef struct {
    int          due;
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       q[$];
  int          nChecks = 0;
  int          nFail = 0;
  bit          done = 1'b0;
  logic [31:0] modelEn = '0;

  // Drives one bus cycle and queues what the requirements predict.
  task automatic cyc(input logic wa, input logic wr, input logic [31:0] wd,
                     input logic [31:0] src, input string tag);
    logic [31:0] live;
    logic [1:0]  grpExp;
    @(negedge clk);
    busAddr = wa; busWr = wr; busWrData = wd; srcIrq = src;
    live = src & CONN & ~FWD;
    grpExp[0] = |(live & modelEn & GRP0);
    grpExp[1] = |(live & modelEn & GRP1);
    q.push_back('{cycleCnt, 0, (wa ? live : modelEn), tag});
    q.push_back('{cycleCnt, 2, (src & FWD), tag});
    q.push_back('{cycleCnt + 1, 1, {30'b0, grpExp}, tag});
    if (wr && !wa) modelEn = wd;
  endtask

  // Monitor: compares due items shortly before the next rising edge.
  initial begin
    forever begin
      item_t       it;
      logic [31:0] act;
      @(negedge clk);
      #3;
      while (q.size() > 0 && q[0].due <= cycleCnt) begin
        it = q.pop_front();
        case (it.sel)
          0:       act = busRdData;
          1:       act = {30'b0, grpIrq};
          default: act = fwdIrq;
        endcase
        nChecks++;
        if (it.due != cycleCnt || act !== it.exp) begin
          nFail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc(1'b0, 1'b0, '0, '0, "R1 reset enable and groups");
    cyc(1'b0, 1'b1, 32'hFFFF_FFFF, '0, "R2 write enable");
    cyc(1'b0, 1'b0, '0, '0, "R2 enable readback");
    cyc(1'b1, 1'b0, '0, 32'hFFFF_FFFF, "R3/R9 status all high");
    cyc(1'b1, 1'b1, '0, '0, "R4 status write, R5 deassert");
    cyc(1'b0, 1'b0, '0, '0, "R4 enable kept");
    cyc(1'b1, 1'b0, '0, 32'h0000_0040, "R6 source 6 to group 1");
    cyc(1'b1, 1'b0, '0, 32'h0000_0200, "R6 source 9 to group 0");
    cyc(1'b1, 1'b0, '0, 32'h0000_0100, "R6 source 8 to group 1");
    cyc(1'b1, 1'b0, '0, 32'h0000_0007, "R7 forwarded only");
    cyc(1'b0, 1'b1, '0, 32'hFFFF_FFFF, "R5 old enable used at write edge");
    cyc(1'b1, 1'b0, '0, 32'hFFFF_FFFF, "R5/R7 disabled groups, bypass live");
    cyc(1'b0, 1'b1, 32'hFFFF_F000, 32'hFFFF_FFFF, "R9 enable unconnected");
    cyc(1'b1, 1'b0, '0, 32'hFFFF_F000, "R9 unconnected silent");
    cyc(1'b0, 1'b1, 32'h0000_0007, 32'h0000_0005, "R7 enable forwarded");
    cyc(1'b1, 1'b0, '0, 32'h0000_00F7, "R7/R8 forwarded skip groups");
    cyc(1'b0, 1'b1, 32'h0000_0008, '0, "R2 enable source 3");
    cyc(1'b1, 1'b0, '0, 32'h0000_0008, "R5 source 3 asserts group 0");
    cyc(1'b1, 1'b0, '0, 32'h0000_0000, "R5 source 3 drop");
    cyc(1'b0, 1'b0, '0, 32'h8000_0002, "R8 bypass high bit gated");
    repeat (3) @(negedge clk);
    #4;
    if (q.size() != 0) begin
      nChecks++; nFail++;
      $display("FAIL scoreboard R5 actual=%0d expected=0 pending items", q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule